// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial audio stream into parallel samples. The stream has a bit clock, a word clock and up to three data pins. All three inputs are oversampled by a faster system clock, which must run at least four times the bit-clock rate. The block resynchronises them to that clock and finds the bit-clock edges. It counts bit positions from the word-clock boundary that the selected framing mode defines. A combinational slot map then decides, for each bit, whether it is a data bit and, if so, which channel and bit index it belongs to.

The receiver handles four stereo framings, which carry one stereo pair on each data pin. It also handles two packed framings, which carry all six channels on the first data pin. A received word is written MSB first into a 24-bit lane. When the last bit of the last word in a frame has arrived, all six lanes are copied to the output bank together and a one-cycle strobe is raised. Words are two's complement and are not sign-extended; shorter words keep their top bits and are zero-filled below.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst_ni` is low, every channel output reads zero and `frame_valid_o` is low.
- R2: With `mode_i`=000, the word clock is low for the left word and high for the right word. The MSB arrives on the second bit-clock rising edge after the word-clock edge. Channel c occupies `ch_o[24c+23:24c]`. Channel 2p is the left word of data pin p and channel 2p+1 is its right word.
- R3: With `mode_i`=011, the word clock is high for the left word. The MSB is the bit sampled on the first rising bit-clock edge after the word clock toggles.
- R4: With `mode_i`=001, the word clock is high for the left word, and each half-frame is 32 bit clocks long. The LSB sits in the last bit clock of the half, so the MSB sits in bit 32−W of the half, counting the first bit of the half as 0.
- R5: With `mode_i`=010, every rising edge of the frame sync starts a word, and the MSB follows one bit clock later. Bits are taken on falling bit-clock edges. Words alternate left then right, and the first word after lock is left.
- R6: With `mode_i`=100, a 256-bit-clock frame starts where the word clock falls, and bits are taken on falling edges. The frame has eight 32-bit slots in the order L1 L2 L3 blank R1 R2 R3 blank, all on data pin 0. The MSB is one bit clock after the slot start. The word clock is low during the left slots. Pins 1 and 2 are ignored.
- R7: With `mode_i`=101, a 128-bit-clock frame starts where the word clock rises, and bits are taken on falling edges. The left group has three 20-bit slots followed by a 4-bit gap, and the right group has the same layout. All data is on pin 0, and the MSB is at each slot start. The word length is 20 bits whatever `wlen_i` holds.
- R8: `wlen_i` selects 24 bits (00), 20 bits (01) or 16 bits (10); code 11 is treated as 24. A shorter word is left-aligned in its 24-bit channel, and the bits below it are zero.
- R9: `frame_valid_o` is a single-cycle pulse raised after the final bit of a frame is captured. The channel outputs change only in the cycle where that pulse is high.
- R10: After reset, and after any change of `mode_i`, nothing is captured until the first word-clock boundary of the new mode. Modes 110 and 111 capture nothing, so no pulse is raised and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Word clock or frame sync |
| sdin_i | input | 3 | Serial data pins, one per stereo pair |
| mode_i | input | 3 | Framing mode select |
| wlen_i | input | 2 | Word-length select |
| ch_o | output | 144 | Six 24-bit MSB-aligned samples; channel c at bits 24c+23..24c |
| frame_valid_o | output | 1 | One-cycle strobe when a new frame is presented |

## Verification
The hardest state to reach from the ports is a receiver that sees data bits before it has ever seen a frame boundary. Without the lock rule, such bits would be taken as valid words and would raise a bogus strobe. The bench reaches this state by resetting the block and then feeding a complete right-channel half-word with no preceding word-clock edge. It checks that no strobe appears, and then that the next properly framed frame is received intact. Unused bit positions and the ignored pins are driven with ones. A mis-timed slot map therefore shows up as wrong sample bits, not as lucky zeros.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [2:0] {
    FMT_I2S   = 3'b000,
    FMT_RJ    = 3'b001,
    FMT_DSP   = 3'b010,
    FMT_LJ    = 3'b011,
    FMT_PK256 = 3'b100,
    FMT_PK128 = 3'b101,
    FMT_TDM   = 3'b110,
    FMT_RSVD  = 3'b111
  } fmt_e;

  localparam int HALF_BCLKS  = 32;
  localparam int PK_LANES    = 3;
  localparam int PK256_SLOT  = 32;
  localparam int PK256_HALF  = PK256_SLOT * (PK_LANES + 1);
  localparam int PK128_SLOT  = 20;
  localparam int PK128_HALF  = 64;
  localparam int PK128_USED  = PK128_SLOT * PK_LANES;

  function automatic int word_bits(fmt_e f, logic [1:0] wl);
    if (f == FMT_PK128) return PK128_SLOT;
    case (wl)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic is_packed(fmt_e f);
    return (f == FMT_PK256) || (f == FMT_PK128);
  endfunction

  function automatic logic on_fall(fmt_e f);
    return (f == FMT_DSP) || is_packed(f);
  endfunction
endpackage

// File: rtl/aud_rx_edge_sync.sv
module aud_rx_edge_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_i,
  input  logic [W-1:0] dat_i,
  output logic         rise_o,
  output logic         fall_o,
  output logic [W-1:0] dat_o
);
  // pipe[STAGES] lags pipe[STAGES-1] by one cycle; data is taken from the
  // older stage so it is the value present just before the detected edge
  logic [STAGES:0][W:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe <= '0;
    end else begin
      pipe[0] <= {bclk_i, dat_i};
      for (int s = 1; s <= STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign rise_o = pipe[STAGES-1][W] & ~pipe[STAGES][W];
  assign fall_o = ~pipe[STAGES-1][W] & pipe[STAGES][W];
  assign dat_o  = pipe[STAGES][W-1:0];
endmodule

// File: rtl/aud_rx_slot_map.sv
module aud_rx_slot_map
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int KW    = 5
) (
  input  fmt_e             fmt_i,
  input  logic [1:0]       wlen_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lr_i,
  input  logic             dsp_sel_i,
  output logic             vld_o,
  output logic             half_o,
  output logic [1:0]       pair_o,
  output logic [KW-1:0]    kbit_o,
  output logic             frame_end_o
);
  always_comb begin
    int c, w, k, slot, pos;
    logic h, v;
    c    = int'(cnt_i);
    w    = word_bits(fmt_i, wlen_i);
    k    = 0;
    slot = 0;
    pos  = 0;
    h    = 1'b0;
    v    = 1'b0;
    case (fmt_i)
      FMT_I2S: begin
        h = lr_i;
        k = c - 1;
        v = (c >= 1) && (c <= w);
      end
      FMT_LJ: begin
        h = !lr_i;
        k = c;
        v = c < w;
      end
      FMT_RJ: begin
        h = !lr_i;
        k = c - (HALF_BCLKS - w);
        v = (k >= 0) && (c < HALF_BCLKS);
      end
      FMT_DSP: begin
        h = dsp_sel_i;
        k = c - 1;
        v = (c >= 1) && (c <= w);
      end
      FMT_PK256: begin
        h    = (c / PK256_HALF) == 1;
        slot = (c % PK256_HALF) / PK256_SLOT;
        k    = (c % PK256_SLOT) - 1;
        v    = (c < 2 * PK256_HALF) && (slot < PK_LANES) && (k >= 0) && (k < w);
      end
      FMT_PK128: begin
        h    = (c / PK128_HALF) == 1;
        pos  = c % PK128_HALF;
        slot = pos / PK128_SLOT;
        k    = pos - PK128_SLOT * slot;
        v    = (c < 2 * PK128_HALF) && (pos < PK128_USED);
      end
      default: v = 1'b0;
    endcase
    vld_o       = v;
    half_o      = h;
    pair_o      = 2'(slot);
    kbit_o      = KW'(k);
    frame_end_o = v && (k == w - 1) && h &&
                  (!is_packed(fmt_i) || slot == PK_LANES - 1);
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int NUM_PINS    = 3,
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 9
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bclk_i,
  input  logic                           lrclk_i,
  input  logic [NUM_PINS-1:0]            sdin_i,
  input  logic [2:0]                     mode_i,
  input  logic [1:0]                     wlen_i,
  output logic [2*NUM_PINS*SAMPLE_W-1:0] ch_o,
  output logic                           frame_valid_o
);
  localparam int NCH = 2 * NUM_PINS;
  localparam int KW  = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                rise, fall, lr_d;
  logic [NUM_PINS-1:0] sd_d;

  aud_rx_edge_sync #(.W(NUM_PINS + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (bclk_i),
    .dat_i  ({lrclk_i, sdin_i}),
    .rise_o (rise),
    .fall_o (fall),
    .dat_o  ({lr_d, sd_d})
  );

  fmt_e fmt, mode_q;
  assign fmt = fmt_e'(mode_i);

  logic             primed_q, lr_q, locked_q, dsp_sel_q, fe_q;
  logic [CNT_W-1:0] cnt_q, cnt_cur;
  logic             smp, mode_chg, bnd_raw, boundary, dsp_sel_cur, pk;

  assign pk       = is_packed(fmt);
  assign smp      = on_fall(fmt) ? fall : rise;
  assign mode_chg = fmt != mode_q;

  always_comb begin
    case (fmt)
      FMT_I2S, FMT_LJ, FMT_RJ: bnd_raw = lr_d ^ lr_q;
      FMT_DSP, FMT_PK128:      bnd_raw = lr_d & ~lr_q;
      FMT_PK256:               bnd_raw = ~lr_d & lr_q;
      default:                 bnd_raw = 1'b0;
    endcase
  end

  assign boundary    = primed_q && bnd_raw;
  assign cnt_cur     = boundary ? '0 : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);
  assign dsp_sel_cur = boundary ? (locked_q & ~dsp_sel_q) : dsp_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= FMT_I2S;
      primed_q  <= 1'b0;
      lr_q      <= 1'b0;
      cnt_q     <= '0;
      locked_q  <= 1'b0;
      dsp_sel_q <= 1'b0;
    end else if (mode_chg) begin
      mode_q   <= fmt;
      locked_q <= 1'b0;
    end else if (smp) begin
      primed_q  <= 1'b1;
      lr_q      <= lr_d;
      cnt_q     <= cnt_cur;
      dsp_sel_q <= dsp_sel_cur;
      if (boundary) locked_q <= 1'b1;
    end
  end

  logic          vld, half, fend;
  logic [1:0]    pair;
  logic [KW-1:0] kbit;

  aud_rx_slot_map #(.CNT_W(CNT_W), .KW(KW)) u_map (
    .fmt_i       (fmt),
    .wlen_i      (wlen_i),
    .cnt_i       (cnt_cur),
    .lr_i        (lr_d),
    .dsp_sel_i   (dsp_sel_cur),
    .vld_o       (vld),
    .half_o      (half),
    .pair_o      (pair),
    .kbit_o      (kbit),
    .frame_end_o (fend)
  );

  logic cap;
  assign cap = smp && !mode_chg && (locked_q || boundary) && vld;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    localparam int   PIN  = c / 2;
    localparam logic SIDE = logic'(c % 2);
    logic                en, d;
    logic [SAMPLE_W-1:0] asm_q, out_q;

    assign d  = pk ? sd_d[0] : sd_d[PIN];
    assign en = cap && (half == SIDE) && (!pk || pair == 2'(PIN));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        asm_q <= '0;
        out_q <= '0;
      end else begin
        if (en) begin
          if (kbit == '0) asm_q <= {d, {(SAMPLE_W-1){1'b0}}};
          else            asm_q[SAMPLE_W-1-int'(kbit)] <= d;
        end
        if (fe_q) out_q <= asm_q;
      end
    end

    assign ch_o[c*SAMPLE_W +: SAMPLE_W] = out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fe_q          <= 1'b0;
      frame_valid_o <= 1'b0;
    end else begin
      fe_q          <= cap && fend;
      frame_valid_o <= fe_q;
    end
  end
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int CHW = 144
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           frame_valid_i,
  input logic [CHW-1:0] ch_i,
  input logic [2:0]     mode_i,
  input logic           locked_i
);
  p_valid_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> !frame_valid_i);

  p_hold_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |-> $stable(ch_i));

  p_no_valid_unsupported_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |-> ($past(mode_i, 2) != 3'b110 && $past(mode_i, 2) != 3'b111));

  p_valid_after_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |-> $past(locked_i));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.CHW(2 * NUM_PINS * SAMPLE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_o),
  .ch_i          (ch_o),
  .mode_i        (mode_i),
  .locked_i      (locked_q)
);

// File: tb/aud_serial_rx_test.sv
`timescale 1ns/1ps
module aud_serial_rx_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         bclk = 1'b0;
  logic         lrclk = 1'b0;
  logic [2:0]   sdin = '0;
  logic [2:0]   mode = '0;
  logic [1:0]   wlen = '0;
  logic [143:0] ch;
  logic         fv;

  aud_serial_rx uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bclk_i        (bclk),
    .lrclk_i       (lrclk),
    .sdin_i        (sdin),
    .mode_i        (mode),
    .wlen_i        (wlen),
    .ch_o          (ch),
    .frame_valid_o (fv)
  );

  always #2 clk = ~clk;

  int   nchk = 0, nfail = 0, vcnt = 0, dbl = 0;
  logic prev_v = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) begin
    if (fv) begin
      vcnt++;
      if (prev_v) dbl++;
    end
    prev_v <= fv;
  end

  // {mode, wlen, expected width, seed}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {3'b000, 2'b00, 5'd24, 24'h9A1CE3},
    {3'b000, 2'b10, 5'd16, 24'h3355AA},
    {3'b011, 2'b00, 5'd24, 24'hF00F5A},
    {3'b011, 2'b01, 5'd20, 24'h1234EF},
    {3'b001, 2'b00, 5'd24, 24'hC3A58E},
    {3'b001, 2'b10, 5'd16, 24'h0FF1E7},
    {3'b010, 2'b00, 5'd24, 24'h6B2D91},
    {3'b100, 2'b00, 5'd24, 24'hA17F3C},
    {3'b101, 2'b00, 5'd20, 24'h58E2D4},
    {3'b011, 2'b11, 5'd24, 24'h2E9B47},
    {3'b100, 2'b10, 5'd16, 24'h7ACE15},
    {3'b010, 2'b01, 5'd20, 24'h4D8063}
  };

  function automatic logic [23:0] gen(logic [23:0] seed, int c);
    logic [23:0] r;
    r = seed + 24'(c) * 24'h2F4B9D;
    return r ^ (24'hC0FFEE >> c);
  endfunction

  function automatic int wbits(int md, logic [1:0] wl);
    if (md == 5) return 20;
    if (wl == 2'b01) return 20;
    if (wl == 2'b10) return 16;
    return 24;
  endfunction

  function automatic logic lr_at(int md, int i);
    case (md)
      0:       return (i / 32) == 1;
      2:       return (i % 32) == 0;
      4:       return i >= 128;
      5:       return i < 64;
      default: return (i / 32) == 0;
    endcase
  endfunction

  function automatic logic [2:0] d_at(int md, int w, int i, logic [23:0] seed);
    logic [2:0]  d;
    logic [23:0] t;
    int h, j, k, s;
    d = 3'b111;
    if (md == 4) begin
      h = i / 128; s = (i % 128) / 32; k = (i % 32) - 1;
      if (s < 3 && k >= 0 && k < w) begin
        t = gen(seed, 2 * s + h); d[0] = t[23-k];
      end
    end else if (md == 5) begin
      h = i / 64; s = (i % 64) / 20; k = (i % 64) % 20;
      if ((i % 64) < 60) begin
        t = gen(seed, 2 * s + h); d[0] = t[23-k];
      end
    end else begin
      h = i / 32; j = i % 32;
      if (md == 0 || md == 2) k = j - 1;
      else if (md == 1)       k = j - (32 - w);
      else                    k = j;
      if (k >= 0 && k < w)
        for (int p = 0; p < 3; p++) begin
          t = gen(seed, 2 * p + h); d[p] = t[23-k];
        end
    end
    return d;
  endfunction

  function automatic logic [23:0] expect_w(logic [23:0] seed, int c, int w);
    logic [23:0] m;
    m = ~(24'hFFFFFF >> w);
    return gen(seed, c) & m;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(logic l, logic [2:0] d);
    @(negedge clk);
    lrclk = l; sdin = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic play(logic [2:0] dm, int pm, logic [1:0] wl, logic [23:0] seed, bit lead);
    int   n, w;
    logic ll;
    n  = (pm == 4) ? 256 : (pm == 5) ? 128 : 64;
    w  = wbits(pm, wl);
    ll = lr_at(pm, n - 1);
    @(negedge clk);
    mode = dm; wlen = wl;
    if (lead) repeat (2) send_bit(ll, 3'b111);
    for (int i = 0; i < n; i++) send_bit(lr_at(pm, i), d_at(pm, w, i, seed));
    send_bit(ll, 3'b111);
    repeat (12) @(negedge clk);
  endtask

  function automatic string tag_of(int md, int w);
    string b;
    case (md)
      0: b = "R2"; 1: b = "R4"; 2: b = "R5"; 3: b = "R3";
      4: b = "R6"; default: b = "R7";
    endcase
    if (w != 24 && md != 5) b = {b, "/R8"};
    return b;
  endfunction

  logic [23:0] held [6];

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < 6; c++) check("R1", $sformatf("reset ch%0d", c), 32'(ch[c*24 +: 24]), 0);
    check("R1", "reset valid", 32'(fv), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int md, w, v0;
      md = int'(VEC[v][33:31]);
      w  = int'(VEC[v][28:24]);
      v0 = vcnt;
      play(VEC[v][33:31], md, VEC[v][30:29], VEC[v][23:0], 1'b1);
      check("R9", $sformatf("vec%0d pulse count", v), 32'(vcnt - v0), 1);
      for (int c = 0; c < 6; c++)
        check(tag_of(md, w), $sformatf("vec%0d ch%0d", v, c),
              32'(ch[c*24 +: 24]), 32'(expect_w(VEC[v][23:0], c, w)));
    end

    // R10: data before the first boundary after reset is not captured
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; mode = 3'b011; wlen = 2'b00;
    begin
      int v0;
      v0 = vcnt;
      for (int i = 0; i < 32; i++) send_bit(1'b0, 3'b101);
      repeat (8) @(negedge clk);
      check("R10", "no pulse before first boundary", 32'(vcnt - v0), 0);
      play(3'b011, 3, 2'b00, 24'h5EA1D0, 1'b1);
      check("R10", "pulse after lock", 32'(vcnt - v0), 1);
      for (int c = 0; c < 6; c++)
        check("R10", $sformatf("after lock ch%0d", c), 32'(ch[c*24 +: 24]),
              32'(expect_w(24'h5EA1D0, c, 24)));
    end

    // R10: unsupported mode captures nothing and leaves outputs alone
    begin
      int v0;
      for (int c = 0; c < 6; c++) held[c] = ch[c*24 +: 24];
      v0 = vcnt;
      play(3'b110, 3, 2'b00, 24'h13579B, 1'b1);
      check("R10", "no pulse in mode 110", 32'(vcnt - v0), 0);
      for (int c = 0; c < 6; c++)
        check("R10", $sformatf("mode 110 hold ch%0d", c), 32'(ch[c*24 +: 24]), 32'(held[c]));
    end

    check("R9", "pulses wider than one cycle", 32'(dbl), 0);

    // R1: reset again after activity
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 6; c++) check("R1", $sformatf("re-reset ch%0d", c), 32'(ch[c*24 +: 24]), 0);
    check("R1", "re-reset valid", 32'(fv), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule